// File: doc/BRIEF.md
# Addressing Mode Effective Address Generator

This block resolves the operand of an 8-bit processor instruction with a 16-bit address space. The opcode has already been decoded and the program counter points at the first byte after it. The block takes a 4-bit addressing-mode code, the program counter and the two index registers. It reads the operand field through a byte-wide memory read port and works out the effective address. For the indirect forms it fetches the 16-bit little-endian pointer first. Except in the immediate, zero-page and operand-less forms, it then reads the byte stored at the effective address. It returns the effective address, the operand byte and the advanced program counter.

A transaction starts with a one-cycle `start` pulse while the block is idle. It ends with a one-cycle `done` pulse, and the results are held until the next accepted start. A raw flag is meant for disassembly. When it is set, the block returns the operand field without any indexing or indirection and performs no pointer or data reads. Codes outside the thirteen defined modes raise `err` and complete without touching memory.

Top module: `ea_resolver`

## Requirements
- R1: Mode codes are 0 accumulator, 1 implied, 2 immediate, 3 zero page, 4 absolute, 5 relative, 6 indirect, 7 absolute+X, 8 absolute+Y, 9 zero page+X, 10 zero page+Y, 11 pre-indexed indirect (X), 12 post-indexed indirect (Y). Modes 0 and 1 read nothing, give ea=0 and operand=0, and leave pc_out equal to pc_in.
- R2: Modes 2 and 3 read one byte b at pc_in and give ea={8'h00,b}, operand=b and pc_out=pc_in+1. They perform no data read.
- R3: Mode 4 reads the low byte at pc_in and the high byte at pc_in+1, sets ea to the assembled address, gives operand=mem[ea] and pc_out=pc_in+2.
- R4: Mode 5 reads an offset byte at pc_in and gives ea=(pc_in+1)+sign_extend(offset) modulo 2^16, operand=mem[ea] and pc_out=pc_in+1.
- R5: Mode 6 reads a 16-bit pointer p as in R3 and gives ea={mem[p+1],mem[p]}, with p+1 formed modulo 2^16. It gives operand=mem[ea] and pc_out=pc_in+2.
- R6: Modes 7 and 8 give ea=(16-bit field)+X or +Y modulo 2^16 and operand=mem[ea].
- R7: Modes 9 and 10 give ea={8'h00,(b+X or Y) mod 256} and operand=mem[ea].
- R8: Mode 11 forms z=(b+X) mod 256 and gives ea={mem[(z+1) mod 256],mem[z]} and operand=mem[ea]. Every pointer read lies in page zero.
- R9: Mode 12 forms base={mem[(b+1) mod 256],mem[b]} and gives ea=base+Y modulo 2^16 and operand=mem[ea].
- R10: With raw_mode set, modes 6 to 12 give the unindexed operand field as ea: 16 bits for modes 6 to 8, {8'h00,b} for modes 9 to 12. Modes 4 and 5 keep their ea. No pointer or data read takes place, operand=ea[7:0], and pc_out advances as without raw_mode.
- R11: Codes 13 to 15 set err=1, ea=0 and operand=0, leave pc_out=pc_in, read nothing, and assert done on the first edge after start. err is 0 after every legal mode.
- R12: start is ignored unless the block is idle. done is a one-cycle pulse. With n operand bytes, p pointer fetches (0 or 1) and d data reads (0 or 1), done is visible after 1 edge when n=0, and otherwise after 2+n+2p+d edges counted from the start edge. mem_rd pulses n+2p+d times.
- R13: During reset, done, err, mem_rd, ea, operand and pc_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| mode | input | 4 | Addressing-mode code |
| raw_mode | input | 1 | Return the operand field without indexing or indirection |
| pc_in | input | 16 | Address of the first operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_addr |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Undefined mode code seen |
| ea | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| pc_out | output | 16 | Program counter after the operand field |

## Verification
The checker assumes that the memory returns `mem_rdata` combinationally in the cycle `mem_addr` is presented. It also assumes that `mode`, `raw_mode`, `pc_in` and the index registers are meaningful only in the cycle `start` is taken, and that memory contents stay fixed during a transaction. The page-zero property on pointer reads relies on the decoder marking only the two zero-page indirect forms. The bench writes memory and drives inputs only on falling edges while the block is idle, and it changes them mid-transaction only in the case that checks `start` is ignored when busy. Its memory model returns data combinationally from the address.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int MODE_W = 4;
  localparam int LAST_MODE = 12;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [MODE_W-1:0] {
    AM_ACCUM   = 4'd0,
    AM_IMPL    = 4'd1,
    AM_IMMED   = 4'd2,
    AM_ZPAGE   = 4'd3,
    AM_ABSOL   = 4'd4,
    AM_RELAT   = 4'd5,
    AM_INDIR   = 4'd6,
    AM_ABS_X   = 4'd7,
    AM_ABS_Y   = 4'd8,
    AM_ZPG_X   = 4'd9,
    AM_ZPG_Y   = 4'd10,
    AM_PRE_IX  = 4'd11,
    AM_POST_IX = 4'd12
  } amode_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] n_bytes;
    logic       idx_en;
    logic       idx_y;
    logic       zp_form;
    logic       via_ptr;
    logic       post_idx;
    logic       rel;
    logic       fetch_data;
  } mode_info_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP_LO, ST_OP_HI, ST_RESOLVE,
    ST_PTR_LO, ST_PTR_HI, ST_DATA, ST_DONE
  } eag_state_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= MODE_W'(LAST_MODE);
  endfunction

  function automatic logic [1:0] mode_byte_count(input logic [MODE_W-1:0] m);
    logic [1:0] n;
    case (m)
      AM_ACCUM, AM_IMPL:                 n = 2'd0;
      AM_ABSOL, AM_INDIR,
      AM_ABS_X, AM_ABS_Y:                n = 2'd2;
      AM_IMMED, AM_ZPAGE, AM_RELAT,
      AM_ZPG_X, AM_ZPG_Y,
      AM_PRE_IX, AM_POST_IX:             n = 2'd1;
      default:                           n = 2'd0;
    endcase
    return n;
  endfunction

  function automatic addr_t page0(input byte_t b);
    return {{BYTE_W{1'b0}}, b};
  endfunction

  function automatic addr_t zp_sum(input byte_t b, input byte_t i);
    byte_t s;
    s = b + i;
    return page0(s);
  endfunction

  function automatic addr_t full_sum(input addr_t a, input byte_t i);
    return a + page0(i);
  endfunction

  function automatic addr_t rel_dest(input addr_t pc_after, input byte_t off);
    return pc_after + {{BYTE_W{off[BYTE_W-1]}}, off};
  endfunction

  function automatic addr_t ptr_step(input addr_t p, input logic zp);
    byte_t lo;
    lo = p[BYTE_W-1:0] + 1'b1;
    return zp ? page0(lo) : p + 1'b1;
  endfunction
endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              raw,
  output mode_info_t        info
);
  logic walk;
  assign walk = !raw;

  always_comb begin
    info = '0;
    info.legal   = mode_legal(mode);
    info.n_bytes = mode_byte_count(mode);
    case (mode)
      AM_ABSOL: info.fetch_data = walk;
      AM_RELAT: begin
        info.rel        = 1'b1;
        info.fetch_data = walk;
      end
      AM_INDIR: begin
        info.via_ptr    = walk;
        info.fetch_data = walk;
      end
      AM_ABS_X, AM_ABS_Y: begin
        info.idx_en     = walk;
        info.idx_y      = (mode == AM_ABS_Y);
        info.fetch_data = walk;
      end
      AM_ZPG_X, AM_ZPG_Y: begin
        info.zp_form    = 1'b1;
        info.idx_en     = walk;
        info.idx_y      = (mode == AM_ZPG_Y);
        info.fetch_data = walk;
      end
      AM_PRE_IX: begin
        info.zp_form    = 1'b1;
        info.via_ptr    = walk;
        info.idx_en     = walk;
        info.fetch_data = walk;
      end
      AM_POST_IX: begin
        info.zp_form    = 1'b1;
        info.via_ptr    = walk;
        info.idx_en     = walk;
        info.idx_y      = 1'b1;
        info.post_idx   = 1'b1;
        info.fetch_data = walk;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
  import eag_pkg::*;
(
  input  mode_info_t info,
  input  addr_t      field,
  input  addr_t      pc_after,
  input  byte_t      idx_x,
  input  byte_t      idx_y,
  input  addr_t      ptr_cur,
  input  byte_t      ptr_lo,
  input  byte_t      ptr_hi,
  output addr_t      direct_ea,
  output addr_t      ptr_base,
  output addr_t      ptr_next,
  output addr_t      ind_ea
);
  byte_t idx_term;
  byte_t post_term;
  byte_t fld_lo;

  assign fld_lo    = field[BYTE_W-1:0];
  assign idx_term  = info.idx_en ? (info.idx_y ? idx_y : idx_x) : '0;
  assign post_term = info.post_idx ? idx_term : '0;

  always_comb begin
    if (info.n_bytes == 2'd0)      direct_ea = '0;
    else if (info.rel)             direct_ea = rel_dest(pc_after, fld_lo);
    else if (info.n_bytes == 2'd2) direct_ea = full_sum(field, idx_term);
    else                           direct_ea = zp_sum(fld_lo, idx_term);
  end

  always_comb begin
    if (info.n_bytes == 2'd2)  ptr_base = field;
    else if (info.post_idx)    ptr_base = page0(fld_lo);
    else                       ptr_base = zp_sum(fld_lo, idx_term);
  end

  assign ptr_next = ptr_step(ptr_cur, info.zp_form);
  assign ind_ea   = full_sum({ptr_hi, ptr_lo}, post_term);
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              raw_mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BYTE_W-1:0] idx_x,
  input  logic [BYTE_W-1:0] idx_y,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] ea,
  output logic [BYTE_W-1:0] operand,
  output logic [ADDR_W-1:0] pc_out
);
  eag_state_e        state_q;
  logic [MODE_W-1:0] mode_q;
  logic              raw_q;
  byte_t             x_q, y_q, ptr_lo_q, opnd_q;
  addr_t             pc_q, field_q, ptr_q, ea_q;
  logic              err_q;
  mode_info_t        info;
  addr_t             direct_ea, ptr_base, ptr_next, ind_ea;

  // Events brought out for the checker
  logic busy, ev_accept, ev_illegal, ev_zp_ptr_rd;
  assign busy         = (state_q != ST_IDLE);
  assign ev_accept    = start && !busy;
  assign ev_illegal   = ev_accept && !mode_legal(mode);
  assign ev_zp_ptr_rd = ((state_q == ST_PTR_LO) || (state_q == ST_PTR_HI)) && info.zp_form;

  eag_mode_decode u_dec (
    .mode (mode_q),
    .raw  (raw_q),
    .info (info)
  );

  eag_addr_calc u_calc (
    .info      (info),
    .field     (field_q),
    .pc_after  (pc_q),
    .idx_x     (x_q),
    .idx_y     (y_q),
    .ptr_cur   (ptr_q),
    .ptr_lo    (ptr_lo_q),
    .ptr_hi    (mem_rdata),
    .direct_ea (direct_ea),
    .ptr_base  (ptr_base),
    .ptr_next  (ptr_next),
    .ind_ea    (ind_ea)
  );

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    case (state_q)
      ST_OP_LO, ST_OP_HI: begin mem_rd = 1'b1; mem_addr = pc_q;     end
      ST_PTR_LO:          begin mem_rd = 1'b1; mem_addr = ptr_q;    end
      ST_PTR_HI:          begin mem_rd = 1'b1; mem_addr = ptr_next; end
      ST_DATA:            begin mem_rd = 1'b1; mem_addr = ea_q;     end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      raw_q    <= 1'b0;
      x_q      <= '0;
      y_q      <= '0;
      pc_q     <= '0;
      field_q  <= '0;
      ptr_q    <= '0;
      ptr_lo_q <= '0;
      ea_q     <= '0;
      opnd_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          mode_q  <= mode;
          raw_q   <= raw_mode;
          x_q     <= idx_x;
          y_q     <= idx_y;
          pc_q    <= pc_in;
          field_q <= '0;
          err_q   <= !mode_legal(mode);
          if (!mode_legal(mode) || mode_byte_count(mode) == 2'd0) begin
            ea_q    <= '0;
            opnd_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_OP_LO;
          end
        end
        ST_OP_LO: begin
          field_q[BYTE_W-1:0] <= mem_rdata;
          pc_q                <= pc_q + 1'b1;
          state_q <= (info.n_bytes == 2'd2) ? ST_OP_HI : ST_RESOLVE;
        end
        ST_OP_HI: begin
          field_q[ADDR_W-1:BYTE_W] <= mem_rdata;
          pc_q                     <= pc_q + 1'b1;
          state_q                  <= ST_RESOLVE;
        end
        ST_RESOLVE: begin
          ptr_q <= ptr_base;
          if (info.via_ptr) begin
            state_q <= ST_PTR_LO;
          end else begin
            ea_q    <= direct_ea;
            opnd_q  <= direct_ea[BYTE_W-1:0];
            state_q <= info.fetch_data ? ST_DATA : ST_DONE;
          end
        end
        ST_PTR_LO: begin
          ptr_lo_q <= mem_rdata;
          state_q  <= ST_PTR_HI;
        end
        ST_PTR_HI: begin
          ea_q    <= ind_ea;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          opnd_q  <= mem_rdata;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done    = (state_q == ST_DONE);
  assign err     = err_q;
  assign ea      = ea_q;
  assign operand = opnd_q;
  assign pc_out  = pc_q;
endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk
  import eag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              err,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ea,
  input logic              busy,
  input logic              ev_illegal,
  input logic              ev_zp_ptr_rd
);
  // R12: done lasts a single cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: no memory traffic while idle
  p_idle_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);

  // R11: an undefined code finishes on the next edge with err and ea cleared
  p_illegal_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> (done && err && ea == '0));

  // R11: an undefined code causes no read
  p_illegal_noread_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |=> !mem_rd);

  // R8 / R9: zero-page pointer fetches stay in page zero
  p_zp_ptr_page0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zp_ptr_rd |-> (mem_rd && mem_addr[ADDR_W-1:BYTE_W] == '0));
endmodule

bind ea_resolver ea_resolver_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .err          (err),
  .mem_rd       (mem_rd),
  .mem_addr     (mem_addr),
  .ea           (ea),
  .busy         (busy),
  .ev_illegal   (ev_illegal),
  .ev_zp_ptr_rd (ev_zp_ptr_rd)
);

// File: tb/ea_resolver_bench.sv
`timescale 1ns/1ps
module ea_resolver_bench;
  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        raw_mode = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  idx_x = '0, idx_y = '0;
  logic        mem_rd, done, err;
  logic [15:0] mem_addr, ea, pc_out;
  logic [7:0]  mem_rdata, operand;

  logic [7:0] mem [0:4095];
  int n_chk = 0, n_bad = 0, rd_cnt = 0;

  always #HALF clk = ~clk;
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (rst_n && mem_rd) rd_cnt++;

  ea_resolver u_ea_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .raw_mode(raw_mode),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .err(err),
    .ea(ea), .operand(operand), .pc_out(pc_out)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem[a[11:0]];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_case(input string tag, input logic [3:0] m, input logic rawf,
                         input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                         input logic [15:0] eea, input logic [15:0] epc, input logic eerr,
                         input int nb, input int np, input int nd, input logic op_from_mem);
    int lat, lat_exp, rd_exp;
    logic [7:0] eop;
    eop     = op_from_mem ? rd(eea) : eea[7:0];
    lat_exp = (nb == 0) ? 1 : 2 + nb + 2*np + nd;
    rd_exp  = nb + 2*np + nd;
    @(negedge clk);
    mode = m; raw_mode = rawf; pc_in = pc; idx_x = x; idx_y = y;
    start = 1'b1; rd_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " ea"}, ea, eea);
    chk({tag, " operand"}, operand, eop);
    chk({tag, " pc_out"}, pc_out, epc);
    chk({tag, " err"}, err, eerr);
    chk({tag, " R12 latency"}, lat, lat_exp);
    chk({tag, " R12 reads"}, rd_cnt, rd_exp);
    @(negedge clk);
    chk({tag, " R12 done pulse"}, done, 0);
  endtask

  task automatic t_reset();
    chk("R13 done", done, 0);
    chk("R13 err", err, 0);
    chk("R13 mem_rd", mem_rd, 0);
    chk("R13 ea", ea, 0);
    chk("R13 operand", operand, 0);
    chk("R13 pc_out", pc_out, 0);
  endtask

  task automatic t_no_operand();
    do_case("R1 accum", 4'd0, 0, 16'h0200, 8'h11, 8'h22, 16'h0000, 16'h0200, 0, 0, 0, 0, 0);
    do_case("R1 implied", 4'd1, 0, 16'h0207, 8'h11, 8'h22, 16'h0000, 16'h0207, 0, 0, 0, 0, 0);
  endtask

  task automatic t_one_byte();
    mem[12'h210] = 8'hA7;
    do_case("R2 immediate", 4'd2, 0, 16'h0210, 8'h00, 8'h00, 16'h00A7, 16'h0211, 0, 1, 0, 0, 0);
    do_case("R2 zero page", 4'd3, 0, 16'h0210, 8'h05, 8'h06, 16'h00A7, 16'h0211, 0, 1, 0, 0, 0);
  endtask

  task automatic t_absolute();
    mem[12'h220] = 8'h34; mem[12'h221] = 8'h05; mem[12'h534] = 8'h9C;
    do_case("R3 absolute", 4'd4, 0, 16'h0220, 8'h00, 8'h00, 16'h0534, 16'h0222, 0, 2, 0, 1, 1);
  endtask

  task automatic t_relative();
    mem[12'h230] = 8'h10;
    do_case("R4 forward", 4'd5, 0, 16'h0230, 8'h00, 8'h00, 16'h0241, 16'h0231, 0, 1, 0, 1, 1);
    mem[12'h230] = 8'hF0;
    do_case("R4 backward", 4'd5, 0, 16'h0230, 8'h00, 8'h00, 16'h0221, 16'h0231, 0, 1, 0, 1, 1);
    mem[12'hFFF] = 8'h05;
    do_case("R4 wrap", 4'd5, 0, 16'hFFFF, 8'h00, 8'h00, 16'h0005, 16'h0000, 0, 1, 0, 1, 1);
  endtask

  task automatic t_indirect();
    mem[12'h240] = 8'h00; mem[12'h241] = 8'h03;
    mem[12'h300] = 8'h78; mem[12'h301] = 8'h06; mem[12'h678] = 8'h3D;
    do_case("R5 indirect", 4'd6, 0, 16'h0240, 8'h00, 8'h00, 16'h0678, 16'h0242, 0, 2, 1, 1, 1);
    mem[12'h244] = 8'hFF; mem[12'h245] = 8'h03;
    mem[12'h3FF] = 8'h9A; mem[12'h400] = 8'h07; mem[12'h300] = 8'h55;
    do_case("R5 ptr page cross", 4'd6, 0, 16'h0244, 8'h00, 8'h00, 16'h079A, 16'h0246, 0, 2, 1, 1, 1);
  endtask

  task automatic t_abs_indexed();
    mem[12'h250] = 8'hF0; mem[12'h251] = 8'h0F;
    do_case("R6 abs+X", 4'd7, 0, 16'h0250, 8'h20, 8'h01, 16'h1010, 16'h0252, 0, 2, 0, 1, 1);
    mem[12'h251] = 8'hFF;
    do_case("R6 abs+Y wrap", 4'd8, 0, 16'h0250, 8'h01, 8'h20, 16'h0010, 16'h0252, 0, 2, 0, 1, 1);
  endtask

  task automatic t_zp_indexed();
    mem[12'h260] = 8'hF0;
    do_case("R7 zp+X wrap", 4'd9, 0, 16'h0260, 8'h20, 8'h00, 16'h0010, 16'h0261, 0, 1, 0, 1, 1);
    mem[12'h260] = 8'h10;
    do_case("R7 zp+Y", 4'd10, 0, 16'h0260, 8'h77, 8'h05, 16'h0015, 16'h0261, 0, 1, 0, 1, 1);
  endtask

  task automatic t_pre_indexed();
    mem[12'h270] = 8'hFE; mem[12'h0FF] = 8'h22; mem[12'h000] = 8'h07;
    mem[12'h100] = 8'h0B;
    do_case("R8 pre-indexed wrap", 4'd11, 0, 16'h0270, 8'h01, 8'h00, 16'h0722, 16'h0271, 0, 1, 1, 1, 1);
  endtask

  task automatic t_post_indexed();
    mem[12'h280] = 8'hFF; mem[12'h0FF] = 8'h22; mem[12'h000] = 8'h07;
    do_case("R9 post-indexed", 4'd12, 0, 16'h0280, 8'h00, 8'hF0, 16'h0812, 16'h0281, 0, 1, 1, 1, 1);
  endtask

  task automatic t_raw();
    mem[12'h290] = 8'h00; mem[12'h291] = 8'h03;
    do_case("R10 raw indirect", 4'd6, 1, 16'h0290, 8'h00, 8'h00, 16'h0300, 16'h0292, 0, 2, 0, 0, 0);
    do_case("R10 raw abs+X", 4'd7, 1, 16'h0290, 8'h44, 8'h00, 16'h0300, 16'h0292, 0, 2, 0, 0, 0);
    do_case("R10 raw absolute", 4'd4, 1, 16'h0290, 8'h00, 8'h00, 16'h0300, 16'h0292, 0, 2, 0, 0, 0);
    mem[12'h2A0] = 8'hC4;
    do_case("R10 raw zp+X", 4'd9, 1, 16'h02A0, 8'h10, 8'h00, 16'h00C4, 16'h02A1, 0, 1, 0, 0, 0);
    do_case("R10 raw post-indexed", 4'd12, 1, 16'h02A0, 8'h00, 8'h10, 16'h00C4, 16'h02A1, 0, 1, 0, 0, 0);
    do_case("R10 raw pre-indexed", 4'd11, 1, 16'h02A0, 8'h10, 8'h00, 16'h00C4, 16'h02A1, 0, 1, 0, 0, 0);
    mem[12'h2A0] = 8'h04;
    do_case("R10 raw relative", 4'd5, 1, 16'h02A0, 8'h00, 8'h00, 16'h02A5, 16'h02A1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_illegal();
    do_case("R11 code13", 4'd13, 0, 16'h0300, 8'h00, 8'h00, 16'h0000, 16'h0300, 1, 0, 0, 0, 0);
    do_case("R11 code15", 4'd15, 1, 16'h0310, 8'h00, 8'h00, 16'h0000, 16'h0310, 1, 0, 0, 0, 0);
    mem[12'h210] = 8'h3B;
    do_case("R11 err clears", 4'd2, 0, 16'h0210, 8'h00, 8'h00, 16'h003B, 16'h0211, 0, 1, 0, 0, 0);
  endtask

  task automatic t_busy_start();
    int lat;
    mem[12'h240] = 8'h00; mem[12'h241] = 8'h03;
    mem[12'h300] = 8'h78; mem[12'h301] = 8'h06;
    @(negedge clk);
    mode = 4'd6; raw_mode = 0; pc_in = 16'h0240; start = 1'b1; rd_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    mode = 4'd0; pc_in = 16'h0999;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
      if (lat == 4) start = 1'b0;
    end
    chk("R12 busy start ea", ea, 16'h0678);
    chk("R12 busy start pc_out", pc_out, 16'h0242);
    chk("R12 busy start latency", lat, 7);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_no_operand();
    t_one_byte();
    t_absolute();
    t_relative();
    t_indirect();
    t_abs_indexed();
    t_zp_indexed();
    t_pre_indexed();
    t_post_indexed();
    t_raw();
    t_illegal();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule